// File: doc/BRIEF.md
# BCD Calendar Counter with Staged Commit

This block keeps wall-clock time and a calendar date in binary-coded decimal: seconds, minutes, hours, a weekday index, day of month, month and a two-digit year covering 1970 to 2069. A free-running enable at the slow crystal rate (32768 pulses by default) is divided down to one strobe per second. Every strobe advances the time, and the carries ripple through minutes, hours and the calendar fields in the same clock cycle.

Software changes the time through a simple register port. Writes to the field addresses land in a shadow copy and leave the running counters alone. A write to the commit address with bit 15 set copies every shadow field, and the software-supplied leap flag, into the live counters in one cycle. The same write restarts the sub-second divider. Reads always show the live counters. A control bit chooses between 24-hour counting and 12-hour counting with a PM flag. February length comes from the leap flag stored with the year, not from arithmetic on the year.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the live fields read seconds 00, minutes 00, hour 00, weekday 0, day 01, month 01, year 00 with leap flag 0, and the control register reads 1 (24-hour mode).
- R2: Register addresses are 0 seconds (bits 6:0), 1 minutes (bits 6:0), 2 hours (bits 5:0), 3 weekday (bits 2:0), 4 day (bits 5:0), 5 month (bits 4:0), 6 year (bits 7:0, leap flag in bit 15). Writes to addresses 0 to 6 change only the shadow copy, and reads of those addresses keep returning the live value.
- R3: A write to address 7 with bit 15 set copies all seven shadow fields and the leap flag into the live counters at that clock edge. A write to address 7 with bit 15 clear has no effect.
- R4: The seconds field advances once for every TICKS_PER_SEC clock cycles in which tick_en is high, and it holds while tick_en is low.
- R5: A commit in the same cycle as the final tick of a second takes priority: the loaded value is kept, and the next second starts a full TICKS_PER_SEC ticks after the commit.
- R6: Seconds and minutes count 00 to 59 in BCD. The step from 59 returns to 00 and carries into the next field.
- R7: In 24-hour mode hours count 00 to 23. The step from 23:59:59 gives 00:00:00 and advances the date.
- R8: In 12-hour mode the hour field holds 01 to 12 in bits 4:0 and PM in bit 5. The step from 11 gives 12 and toggles PM, and the step from 12 gives 01 with PM unchanged. The date advances only on the step from 11:59:59 PM.
- R9: The day of month wraps to 01 after 31 for months 1, 3, 5, 7, 8, 10 and 12, after 30 for months 4, 6, 9 and 11, and for month 2 after 29 when the leap flag is 1 and after 28 when it is 0.
- R10: A day wrap in month 12 gives month 01 and advances the year, and year 99 wraps to 00. The leap flag never changes on its own.
- R11: The weekday counts 0 to 6 and advances on every day wrap, with 6 going to 0.
- R12: Address 8 bit 0 selects 24-hour mode (1) or 12-hour mode (0). The write takes effect at once, without a commit. rd_data is registered and shows, one clock edge later, the live value at rd_addr, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the slow crystal rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Registered read data of the live fields |

## Verification
A field write or a commit takes effect at the rising edge that samples the strobe. A second advances at the edge that samples the TICKS_PER_SEC-th high tick_en, and all carries into the date settle at that same edge. rd_data then lags the live state by exactly one further edge. The bench drives inputs at falling edges. It reads each register by setting rd_addr and sampling rd_data at the next falling edge, so every value it sees reflects the state after all earlier strobes have been taken. The day-wrap sweeps cover every month under both leap settings and every hour in both clock modes, and they compare against month lengths and hour sequences computed in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int WDAY_W = 3;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;

  localparam int A_SEC    = 0;
  localparam int A_MIN    = 1;
  localparam int A_HOUR   = 2;
  localparam int A_WDAY   = 3;
  localparam int A_DAY    = 4;
  localparam int A_MON    = 5;
  localparam int A_YEAR   = 6;
  localparam int A_COMMIT = 7;
  localparam int A_CTRL   = 8;

  localparam int FLAG_BIT = 15;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [DAY_W-1:0]  day;
    logic [MON_W-1:0]  mon;
    logic [YEAR_W-1:0] year;
    logic              leap;
  } cal_fields_t;

  // Two-digit BCD increment without wrap handling.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Last day of the month, in BCD.
  function automatic logic [DAY_W-1:0] month_last_day(input logic [MON_W-1:0] m,
                                                      input logic leap_f);
    logic [DAY_W-1:0] d;
    case (m)
      5'h02:                      d = leap_f ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clear,
  output logic sec_pulse
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick_en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign sec_pulse = tick_en && (cnt == LAST) && !clear;

  // R5: a commit restarts the sub-second count
  a_r5_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));

  // R4: idle ticks leave the divider untouched
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !clear) |=> $stable(cnt));

endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_pulse,
  input  logic              load,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic              mode24,
  output logic [SEC_W-1:0]  sec,
  output logic [MIN_W-1:0]  min,
  output logic [HOUR_W-1:0] hour,
  output logic              day_carry
);
  logic sec_end, min_end, hour_end;
  logic [HOUR_W-1:0] hour_next;
  logic [7:0] h12_inc;

  assign sec_end = (sec == 7'h59);
  assign min_end = (min == 7'h59);
  assign h12_inc = bcd_inc8({3'b000, hour[4:0]});

  always_comb begin
    if (mode24) begin
      hour_end  = (hour == 6'h23);
      hour_next = hour_end ? 6'h00 : bcd_inc8({2'b00, hour})[5:0];
    end else begin
      hour_end = hour[5] && (hour[4:0] == 5'h11);
      if (hour[4:0] == 5'h12)      hour_next = {hour[5], 5'h01};
      else if (hour[4:0] == 5'h11) hour_next = {~hour[5], 5'h12};
      else                         hour_next = {hour[5], h12_inc[4:0]};
    end
  end

  assign day_carry = sec_pulse && !load && sec_end && min_end && hour_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
    end else if (load) begin
      sec  <= ld_sec;
      min  <= ld_min;
      hour <= ld_hour;
    end else if (sec_pulse) begin
      sec <= sec_end ? 7'h00 : bcd_inc8({1'b0, sec})[6:0];
      if (sec_end) begin
        min <= min_end ? 7'h00 : bcd_inc8({1'b0, min})[6:0];
        if (min_end) hour <= hour_next;
      end
    end
  end

  // R6: seconds wrap from 59 to 00
  a_r6_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !load && sec == 7'h59) |=> (sec == 7'h00));

  // R7: midnight in 24-hour mode
  a_r7_midnight: assert property (@(posedge clk) disable iff (rst)
    (mode24 && day_carry) |=> (hour == 6'h00 && min == 7'h00 && sec == 7'h00));

  // R8: 11 AM rolls to 12 PM in 12-hour mode
  a_r8_noon: assert property (@(posedge clk) disable iff (rst)
    (!mode24 && sec_pulse && !load && sec == 7'h59 && min == 7'h59 && hour == 6'h11)
    |=> (hour == 6'h32));

endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              day_carry,
  input  logic              load,
  input  logic [WDAY_W-1:0] ld_wday,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [MON_W-1:0]  ld_mon,
  input  logic [YEAR_W-1:0] ld_year,
  input  logic              ld_leap,
  output logic [WDAY_W-1:0] wday,
  output logic [DAY_W-1:0]  day,
  output logic [MON_W-1:0]  mon,
  output logic [YEAR_W-1:0] year,
  output logic              leap
);
  logic [DAY_W-1:0] last_day;
  logic month_end, year_end;

  assign last_day  = month_last_day(mon, leap);
  assign month_end = (day >= last_day);
  assign year_end  = (mon == 5'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      wday <= '0;
      day  <= 6'h01;
      mon  <= 5'h01;
      year <= '0;
      leap <= 1'b0;
    end else if (load) begin
      wday <= ld_wday;
      day  <= ld_day;
      mon  <= ld_mon;
      year <= ld_year;
      leap <= ld_leap;
    end else if (day_carry) begin
      wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
      if (month_end) begin
        day <= 6'h01;
        if (year_end) begin
          mon  <= 5'h01;
          year <= (year == 8'h99) ? 8'h00 : bcd_inc8(year);
        end else begin
          mon <= bcd_inc8({3'b000, mon})[4:0];
        end
      end else begin
        day <= bcd_inc8({2'b00, day})[5:0];
      end
    end
  end

  // R11: weekday wraps after 6
  a_r11_wday_wrap: assert property (@(posedge clk) disable iff (rst)
    (day_carry && !load && wday == 3'd6) |=> (wday == 3'd0));

  // R9: leap February reaches the 29th
  a_r9_leap_feb: assert property (@(posedge clk) disable iff (rst)
    (day_carry && !load && leap && mon == 5'h02 && day == 6'h28) |=> (day == 6'h29));

  // R10: century wrap keeps the leap flag
  a_r10_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (day_carry && !load && mon == 5'h12 && day == 6'h31 && year == 8'h99)
    |=> (year == 8'h00 && mon == 5'h01 && day == 6'h01 && $stable(leap)));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  cal_fields_t shadow;
  cal_fields_t live;
  logic mode24;
  logic commit;
  logic sec_pulse;

  assign commit = wr_en && (wr_addr == ADDR_W'(A_COMMIT)) && wr_data[FLAG_BIT];

  // Shadow copy and mode bit
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '{sec: '0, min: '0, hour: '0, wday: '0, day: 6'h01,
                  mon: 5'h01, year: '0, leap: 1'b0};
      mode24 <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_SEC):  shadow.sec  <= wr_data[SEC_W-1:0];
        ADDR_W'(A_MIN):  shadow.min  <= wr_data[MIN_W-1:0];
        ADDR_W'(A_HOUR): shadow.hour <= wr_data[HOUR_W-1:0];
        ADDR_W'(A_WDAY): shadow.wday <= wr_data[WDAY_W-1:0];
        ADDR_W'(A_DAY):  shadow.day  <= wr_data[DAY_W-1:0];
        ADDR_W'(A_MON):  shadow.mon  <= wr_data[MON_W-1:0];
        ADDR_W'(A_YEAR): begin
          shadow.year <= wr_data[YEAR_W-1:0];
          shadow.leap <= wr_data[FLAG_BIT];
        end
        ADDR_W'(A_CTRL): mode24 <= wr_data[0];
        default: ;
      endcase
    end
  end

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .clear     (commit),
    .sec_pulse (sec_pulse)
  );

  logic day_carry;

  cal_time_counter u_time (
    .clk       (clk),
    .rst       (rst),
    .sec_pulse (sec_pulse),
    .load      (commit),
    .ld_sec    (shadow.sec),
    .ld_min    (shadow.min),
    .ld_hour   (shadow.hour),
    .mode24    (mode24),
    .sec       (live.sec),
    .min       (live.min),
    .hour      (live.hour),
    .day_carry (day_carry)
  );

  cal_date_counter u_date (
    .clk       (clk),
    .rst       (rst),
    .day_carry (day_carry),
    .load      (commit),
    .ld_wday   (shadow.wday),
    .ld_day    (shadow.day),
    .ld_mon    (shadow.mon),
    .ld_year   (shadow.year),
    .ld_leap   (shadow.leap),
    .wday      (live.wday),
    .day       (live.day),
    .mon       (live.mon),
    .year      (live.year),
    .leap      (live.leap)
  );

  // Registered read port of the live fields
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(A_SEC):  rd_data <= 16'(live.sec);
        ADDR_W'(A_MIN):  rd_data <= 16'(live.min);
        ADDR_W'(A_HOUR): rd_data <= 16'(live.hour);
        ADDR_W'(A_WDAY): rd_data <= 16'(live.wday);
        ADDR_W'(A_DAY):  rd_data <= 16'(live.day);
        ADDR_W'(A_MON):  rd_data <= 16'(live.mon);
        ADDR_W'(A_YEAR): rd_data <= {live.leap, 7'b0, live.year};
        ADDR_W'(A_CTRL): rd_data <= {15'b0, mode24};
        default:         rd_data <= '0;
      endcase
    end
  end

  // R3: commit copies the staged fields
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
    commit |=> (live.sec == $past(shadow.sec) && live.day == $past(shadow.day)
                && live.year == $past(shadow.year) && live.leap == $past(shadow.leap)));

  // R2: a field write alone leaves the live seconds alone
  a_r2_staged_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_SEC) && !tick_en) |=> $stable(live.sec));

endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) u_bcd_calendar (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] bcd(input int x);
    return 16'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic int mdays(input int m, input int lp);
    if (m == 2) return 28 + lp;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    rd_addr = 4'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] s, input logic [15:0] mi, input logic [15:0] h,
                      input logic [15:0] wd, input logic [15:0] d, input logic [15:0] mo,
                      input logic [15:0] y, input logic lp);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, wd); wr(4, d); wr(5, mo);
    wr(6, {lp, 7'b0, y[7:0]});
    wr(7, 16'h8000);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 sec", v, 16'h0000);
    rd(1, v); chk("R1 min", v, 16'h0000);
    rd(2, v); chk("R1 hour", v, 16'h0000);
    rd(3, v); chk("R1 wday", v, 16'h0000);
    rd(4, v); chk("R1 day", v, 16'h0001);
    rd(5, v); chk("R1 mon", v, 16'h0001);
    rd(6, v); chk("R1 year", v, 16'h0000);
    rd(8, v); chk("R1 ctrl", v, 16'h0001);

    // R2 staged writes invisible; R3 commit without flag ignored
    wr(0, 16'h0045); wr(4, 16'h0017); wr(6, 16'h8024);
    rd(0, v); chk("R2 sec staged", v, 16'h0000);
    rd(4, v); chk("R2 day staged", v, 16'h0001);
    wr(7, 16'h0001);
    rd(0, v); chk("R3 no-flag commit sec", v, 16'h0000);
    rd(6, v); chk("R3 no-flag commit year", v, 16'h0000);
    wr(7, 16'h8000);
    rd(0, v); chk("R3 commit sec", v, 16'h0045);
    rd(4, v); chk("R3 commit day", v, 16'h0017);
    rd(6, v); chk("R3 commit year+leap", v, 16'h8024);

    // R4 divider
    repeat (20) @(negedge clk);
    rd(0, v); chk("R4 hold without tick", v, 16'h0045);
    ticks(TPS - 1);
    rd(0, v); chk("R4 before last tick", v, 16'h0045);
    ticks(1);
    rd(0, v); chk("R4 one second", v, 16'h0046);

    // R5 commit coincides with the final tick
    wr(0, 16'h0010);
    ticks(TPS - 1);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 16'h8000;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(0, v); chk("R5 commit wins", v, 16'h0010);
    ticks(TPS - 1);
    rd(0, v); chk("R5 restart partial", v, 16'h0010);
    ticks(1);
    rd(0, v); chk("R5 restart full", v, 16'h0011);

    // R6 second/minute sweep
    load(16'h00, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h00, 1'b0);
    for (int t = 1; t <= 125; t++) begin
      ticks(TPS);
      rd(0, v); chk("R6 sec sweep", v, bcd(t % 60));
      rd(1, v); chk("R6 min sweep", v, bcd(t / 60));
    end

    // R7 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      load(16'h59, 16'h59, bcd(h), 16'h2, 16'h10, 16'h05, 16'h30, 1'b0);
      ticks(TPS);
      rd(2, v); chk("R7 hour", v, bcd((h + 1) % 24));
      rd(1, v); chk("R6 min wrap", v, 16'h0000);
      rd(4, v); chk("R7 day carry", v, (h == 23) ? 16'h0011 : 16'h0010);
    end

    // R8 12-hour sweep; R12 mode bit
    wr(8, 16'h0000);
    rd(8, v); chk("R12 ctrl 12h", v, 16'h0000);
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh;
        int npm;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        load(16'h59, 16'h59, bcd(h) | 16'(pm << 5), 16'h1, 16'h10, 16'h05, 16'h30, 1'b0);
        ticks(TPS);
        rd(2, v); chk("R8 hour", v, bcd(nh) | 16'(npm << 5));
        rd(4, v); chk("R8 day carry", v, (h == 11 && pm == 1) ? 16'h0011 : 16'h0010);
      end
    end
    wr(8, 16'h0001);
    rd(8, v); chk("R12 ctrl 24h", v, 16'h0001);

    // R9 R10 R11 month-length sweep
    for (int lp = 0; lp < 2; lp++) begin
      for (int m = 1; m <= 12; m++) begin
        int md;
        md = mdays(m, lp);
        load(16'h59, 16'h59, 16'h23, 16'h3, bcd(md - 1), bcd(m), 16'h24, lp[0]);
        ticks(TPS);
        rd(4, v); chk("R9 reach last day", v, bcd(md));
        rd(5, v); chk("R9 month held", v, bcd(m));
        load(16'h59, 16'h59, 16'h23, 16'h3, bcd(md), bcd(m), 16'h24, lp[0]);
        ticks(TPS);
        rd(4, v); chk("R9 wrap day", v, 16'h0001);
        rd(5, v); chk("R10 next month", v, bcd((m == 12) ? 1 : m + 1));
        rd(6, v); chk("R10 year", v, {lp[0], 7'b0, (m == 12) ? 8'h25 : 8'h24});
        rd(3, v); chk("R11 wday step", v, 16'h0004);
      end
    end

    // R10 century wrap; R11 weekday wrap
    load(16'h59, 16'h59, 16'h23, 16'h6, 16'h31, 16'h12, 16'h99, 1'b1);
    ticks(TPS);
    rd(6, v); chk("R10 year 99 wrap", v, 16'h8000);
    rd(5, v); chk("R10 month wrap", v, 16'h0001);
    rd(3, v); chk("R11 wday wrap", v, 16'h0000);
    rd(7, v); chk("R12 commit reads zero", v, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule